// File: doc/BRIEF.md
# Edge-Triggered Event Timestamp Capture

This block stamps external events with the time of a free-running precision clock that lives elsewhere on the chip. Eight event pins are sampled, and the block detects rising and falling transitions on each one. When a transition is enabled, the block stores the seconds and nanoseconds value present on its time input. Every channel keeps a separate record for each edge direction.

Software drives the block through a small word-addressed register port. Through it, software selects which edges capture and which of them are protected from overwrite. It then polls or takes an interrupt. Finally it opens a readout window on one channel to fetch the rising and falling stamps.

The interrupt comes from a write-one-to-clear status word and an enable word. The enable word has separate set and clear addresses, so no read-modify-write is needed.

Top module: `evs_stamp_top`

Register word addresses: 0 capture configuration, 1 status, 2 enable-set, 3 enable-clear, 4 window select, 5 rising seconds, 6 rising nanoseconds (bits 29:0), 7 falling seconds, 8 falling nanoseconds (bits 29:0). Any other address reads zero.

## Requirements
- R1: After reset, the following all read 0: configuration, status, interrupt enable, window select and every stored stamp. `irq_o` is low.
- R2: A rising edge on channel ch is captured when configuration bit ch (rising enable) is 1. The block stores the time present at the third rising clock edge after the pin change, counting the first edge that samples the new level. That is two synchroniser flops plus one edge register.
- R3: A falling edge on channel ch is captured when configuration bit 8+ch (falling enable) is 1. It uses the same latency as R2 and is kept apart from the rising stamp.
- R4: An edge whose enable is 0 stores nothing and sets no status bit.
- R5: Status bit 16+ch flags a rising capture event and bit 24+ch a falling one. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: A write to address 2 sets the enable bits written as 1. A write to address 3 clears the enable bits written as 1. Both addresses read back the enable word, which uses the status bit layout.
- R7: `irq_o` is high exactly when some status bit and its enable bit are both 1.
- R8: Lock bits sit at configuration bit 16+ch for rising and 24+ch for falling. While an edge's lock bit is 1 and its status bit is pending, a new edge leaves the stored stamp unchanged. With the lock bit at 0, each new edge overwrites the stamp.
- R9: Bits 10:8 of the window select register choose the channel whose stamps appear at addresses 5 to 8.
- R10: If a status clear and a new event for the same bit land in the same cycle, the bit stays set.
- R11: The configuration word reads back as written. Its fields are rising enables at 0+ch, falling enables at 8+ch, rising locks at 16+ch and falling locks at 24+ch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Asynchronous event pins, one per channel |
| tod_sec_i | input | 32 | Time counter seconds, low word |
| tod_ns_i | input | 30 | Time counter nanoseconds |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt request |

## Verification
A software write to the status word and a capture on the same channel and edge can hit the same clock edge. The bench provokes this by raising a pin and placing the one-to-clear write so that it lands on the capture edge; it does so while the bit is already pending. The status readback afterwards must still show the bit, and the stamp must hold the time of that clock edge. A later clear with no event must then drop the bit.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int SEC_W = 32;
  localparam int NS_W  = 30;
  localparam int REG_W = 32;
  localparam int ADR_W = 4;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tstamp_t;

  localparam logic [ADR_W-1:0] A_CFG   = 4'd0;
  localparam logic [ADR_W-1:0] A_STAT  = 4'd1;
  localparam logic [ADR_W-1:0] A_IESET = 4'd2;
  localparam logic [ADR_W-1:0] A_IECLR = 4'd3;
  localparam logic [ADR_W-1:0] A_SEL   = 4'd4;
  localparam logic [ADR_W-1:0] A_RSEC  = 4'd5;
  localparam logic [ADR_W-1:0] A_RNS   = 4'd6;
  localparam logic [ADR_W-1:0] A_FSEC  = 4'd7;
  localparam logic [ADR_W-1:0] A_FNS   = 4'd8;
endpackage

// File: rtl/evs_sync_edge.sv
module evs_sync_edge #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] pin_i,
  output logic [N_CH-1:0] rise_o,
  output logic [N_CH-1:0] fall_o
);
  logic [N_CH-1:0] s1_q, s2_q, s3_q;
  logic [N_CH-1:0] s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = pin_i;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_edge
    assign rise_o[g] = s2_q[g] & ~s3_q[g];
    assign fall_o[g] = ~s2_q[g] & s3_q[g];
  end
endmodule

// File: rtl/evs_stamp_store.sv
module evs_stamp_store
  import evs_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] rise_wr_i,
  input  logic [N_CH-1:0] fall_wr_i,
  input  tstamp_t         now_i,
  input  logic [2:0]      sel_i,
  output tstamp_t         rise_sel_o,
  output tstamp_t         fall_sel_o
);
  tstamp_t rise_arr [N_CH];
  tstamp_t fall_arr [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tstamp_t rise_q, rise_d, fall_q, fall_d;

    always_comb begin
      rise_d = rise_wr_i[g] ? now_i : rise_q;
      fall_d = fall_wr_i[g] ? now_i : fall_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_q <= '0;
        fall_q <= '0;
      end else begin
        rise_q <= rise_d;
        fall_q <= fall_d;
      end
    end

    assign rise_arr[g] = rise_q;
    assign fall_arr[g] = fall_q;

    // R2: a rising strobe leaves the counter value of that cycle in storage
    p_rise_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rise_wr_i[g]) |-> (rise_q == $past(now_i)));
    // R3: a falling strobe leaves the counter value of that cycle in storage
    p_fall_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fall_wr_i[g]) |-> (fall_q == $past(now_i)));
  end

  always_comb begin
    rise_sel_o = '0;
    fall_sel_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (sel_i == 3'(i)) begin
        rise_sel_o = rise_arr[i];
        fall_sel_o = fall_arr[i];
      end
    end
  end
endmodule

// File: rtl/evs_regs.sv
module evs_regs
  import evs_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [ADR_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [N_CH-1:0]  rise_ev_i,
  input  logic [N_CH-1:0]  fall_ev_i,
  input  tstamp_t          rise_sel_i,
  input  tstamp_t          fall_sel_i,
  output logic [N_CH-1:0]  rise_wr_o,
  output logic [N_CH-1:0]  fall_wr_o,
  output logic [2:0]       sel_o,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  localparam int HALF = REG_W / 2;

  logic [REG_W-1:0] cfg_q, cfg_d;
  logic [HALF-1:0]  stat_q, stat_d, ien_q, ien_d;
  logic [2:0]       sel_q, sel_d;
  logic [HALF-1:0]  hit_vec, clr_vec;
  logic [N_CH-1:0]  rise_hit, fall_hit, rise_keep, fall_keep;
  logic             wr_cfg, wr_stat, wr_set, wr_clr, wr_sel;

  always_comb begin
    wr_cfg  = wr_en_i && (addr_i == A_CFG);
    wr_stat = wr_en_i && (addr_i == A_STAT);
    wr_set  = wr_en_i && (addr_i == A_IESET);
    wr_clr  = wr_en_i && (addr_i == A_IECLR);
    wr_sel  = wr_en_i && (addr_i == A_SEL);

    rise_hit  = rise_ev_i & cfg_q[0 +: N_CH];
    fall_hit  = fall_ev_i & cfg_q[8 +: N_CH];
    rise_keep = cfg_q[16 +: N_CH] & stat_q[0 +: N_CH];
    fall_keep = cfg_q[24 +: N_CH] & stat_q[8 +: N_CH];
    rise_wr_o = rise_hit & ~rise_keep;
    fall_wr_o = fall_hit & ~fall_keep;

    hit_vec = '0;
    hit_vec[0 +: N_CH] = rise_hit;
    hit_vec[8 +: N_CH] = fall_hit;
    clr_vec = wr_stat ? wdata_i[REG_W-1:HALF] : '0;

    cfg_d  = wr_cfg ? wdata_i : cfg_q;
    sel_d  = wr_sel ? wdata_i[10:8] : sel_q;
    stat_d = (stat_q & ~clr_vec) | hit_vec;
    ien_d  = ien_q;
    if (wr_set) ien_d = ien_q | wdata_i[REG_W-1:HALF];
    if (wr_clr) ien_d = ien_q & ~wdata_i[REG_W-1:HALF];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
      sel_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      stat_q <= stat_d;
      ien_q  <= ien_d;
      sel_q  <= sel_d;
    end
  end

  assign sel_o = sel_q;
  assign irq_o = |(stat_q & ien_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CFG:   rdata_o = cfg_q;
      A_STAT:  rdata_o = {stat_q, {HALF{1'b0}}};
      A_IESET: rdata_o = {ien_q, {HALF{1'b0}}};
      A_IECLR: rdata_o = {ien_q, {HALF{1'b0}}};
      A_SEL:   rdata_o = {21'b0, sel_q, 8'b0};
      A_RSEC:  rdata_o = rise_sel_i.sec;
      A_RNS:   rdata_o = {2'b0, rise_sel_i.ns};
      A_FSEC:  rdata_o = fall_sel_i.sec;
      A_FNS:   rdata_o = {2'b0, fall_sel_i.ns};
      default: rdata_o = '0;
    endcase
  end

  // R4: a status bit only turns on after an enabled edge in the prior cycle
  p_stat_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(hit_vec)) == '0));
  // R5: a one written to status is gone next cycle unless an event hit it
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_stat) |->
      ((stat_q & $past(wdata_i[REG_W-1:HALF]) & ~$past(hit_vec)) == '0));
  // R10: an event always leaves its status bit set, even against a clear
  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & $past(hit_vec)) == $past(hit_vec)));
  // R6: enable-set writes take effect on the next cycle
  p_ien_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_set) |->
      ((ien_q & $past(wdata_i[REG_W-1:HALF])) == $past(wdata_i[REG_W-1:HALF])));
endmodule

// File: rtl/evs_stamp_top.sv
module evs_stamp_top
  import evs_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  evt_i,
  input  logic [SEC_W-1:0] tod_sec_i,
  input  logic [NS_W-1:0]  tod_ns_i,
  input  logic             wr_en_i,
  input  logic [ADR_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [N_CH-1:0] rise_ev, fall_ev, rise_wr, fall_wr;
  logic [2:0]      sel;
  tstamp_t         now, rise_sel, fall_sel;

  assign now.sec = tod_sec_i;
  assign now.ns  = tod_ns_i;

  evs_sync_edge #(.N_CH(N_CH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (evt_i),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  evs_regs #(.N_CH(N_CH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rise_ev_i  (rise_ev),
    .fall_ev_i  (fall_ev),
    .rise_sel_i (rise_sel),
    .fall_sel_i (fall_sel),
    .rise_wr_o  (rise_wr),
    .fall_wr_o  (fall_wr),
    .sel_o      (sel),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o)
  );

  evs_stamp_store #(.N_CH(N_CH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_wr_i  (rise_wr),
    .fall_wr_i  (fall_wr),
    .now_i      (now),
    .sel_i      (sel),
    .rise_sel_o (rise_sel),
    .fall_sel_o (fall_sel)
  );
endmodule

// File: tb/tb_evs_stamp_top.sv
module tb_evs_stamp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt = '0;
  logic [31:0] cnt = '0;
  logic [31:0] tod_sec;
  logic [29:0] tod_ns;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  bit          done = 1'b0;

  always #5 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 32'd1;
  assign tod_sec = (cnt * 32'd3) + 32'h0100_0000;
  assign tod_ns  = 30'(cnt * 32'd7);

  evs_stamp_top dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .tod_sec_i(tod_sec), .tod_ns_i(tod_ns),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct {
    int          req;
    bit          is_irq;
    logic [3:0]  a;
    logic [31:0] exp;
  } item_t;
  item_t q[$];
  int checks = 0;
  int failures = 0;

  // monitor: pops expected items and compares them after the clock edge
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        act = it.is_irq ? {31'b0, irq} : rdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL R%0d addr=%0d actual=%h expected=%h", it.req, it.a, act, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(input int req, input logic [3:0] a, input logic [31:0] e);
    item_t it;
    @(negedge clk);
    addr = a;
    it.req = req; it.is_irq = 1'b0; it.a = a; it.exp = e;
    q.push_back(it);
    @(posedge clk);
    #3;
  endtask

  task automatic exp_irq(input int req, input logic e);
    item_t it;
    @(negedge clk);
    it.req = req; it.is_irq = 1'b1; it.a = addr; it.exp = {31'b0, e};
    q.push_back(it);
    @(posedge clk);
    #3;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // change a pin and return the time value the block samples on capture
  task automatic pin(input int ch, input logic lvl,
                     output logic [31:0] es, output logic [29:0] en);
    @(negedge clk);
    evt[ch] = lvl;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    #1;
    es = tod_sec;
    en = tod_ns;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] s0, s1, s2, s3;
    logic [29:0] n0, n1, n2, n3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    exp_rd(1, 4'd0, 32'h0);
    exp_rd(1, 4'd1, 32'h0);
    exp_rd(1, 4'd2, 32'h0);
    exp_rd(1, 4'd5, 32'h0);
    exp_irq(1, 1'b0);

    // R11: config layout, ch0 rise, ch1 fall, ch2 rise+lock, ch3 rise
    wr(4'd0, 32'h0004_020D);
    exp_rd(11, 4'd0, 32'h0004_020D);

    // R2: rising capture on ch0
    pin(0, 1'b1, s0, n0);
    idle(1);
    exp_rd(2, 4'd5, s0);
    exp_rd(2, 4'd6, {2'b0, n0});
    exp_rd(5, 4'd1, 32'h0001_0000);   // R5 rising status bit 16
    exp_irq(7, 1'b0);                 // R7 disabled

    // R6 / R7: enable set and clear
    wr(4'd2, 32'h0001_0000);
    exp_irq(7, 1'b1);
    exp_rd(6, 4'd3, 32'h0001_0000);
    wr(4'd3, 32'h0001_0000);
    exp_irq(7, 1'b0);
    exp_rd(6, 4'd2, 32'h0);
    wr(4'd2, 32'h0001_0000);

    // R5: write zero keeps, write one clears
    wr(4'd1, 32'h0);
    exp_rd(5, 4'd1, 32'h0001_0000);
    wr(4'd1, 32'h0001_0000);
    exp_rd(5, 4'd1, 32'h0);
    exp_irq(7, 1'b0);

    // R4: disabled edges (ch0 falling, ch5 rising) do nothing
    pin(0, 1'b0, s1, n1);
    pin(5, 1'b1, s1, n1);
    idle(1);
    exp_rd(4, 4'd1, 32'h0);
    exp_rd(4, 4'd7, 32'h0);
    exp_rd(4, 4'd5, s0);

    // R3: falling capture on ch1
    pin(1, 1'b1, s1, n1);
    pin(1, 1'b0, s1, n1);
    idle(1);
    wr(4'd4, 32'h0000_0100);
    exp_rd(9, 4'd4, 32'h0000_0100);   // R9 select readback
    exp_rd(3, 4'd7, s1);
    exp_rd(3, 4'd8, {2'b0, n1});
    exp_rd(3, 4'd5, 32'h0);           // ch1 rising not enabled
    exp_rd(3, 4'd1, 32'h0200_0000);

    // R9: window back to ch0 shows ch0 stamps
    wr(4'd4, 32'h0);
    exp_rd(9, 4'd5, s0);
    exp_rd(9, 4'd6, {2'b0, n0});
    wr(4'd1, 32'h0200_0000);

    // R8: locked channel 2 keeps first stamp while pending
    wr(4'd4, 32'h0000_0200);
    pin(2, 1'b1, s2, n2);
    pin(2, 1'b0, s3, n3);
    pin(2, 1'b1, s3, n3);
    idle(1);
    exp_rd(8, 4'd5, s2);
    exp_rd(8, 4'd6, {2'b0, n2});
    wr(4'd1, 32'h0004_0000);
    pin(2, 1'b0, s3, n3);
    pin(2, 1'b1, s3, n3);
    idle(1);
    exp_rd(8, 4'd5, s3);

    // R8: unlocked channel 3 overwrites
    wr(4'd4, 32'h0000_0300);
    pin(3, 1'b1, s2, n2);
    pin(3, 1'b0, s2, n2);
    pin(3, 1'b1, s3, n3);
    idle(1);
    exp_rd(8, 4'd5, s3);
    exp_rd(8, 4'd6, {2'b0, n3});
    exp_rd(5, 4'd1, 32'h000C_0000);

    // R10: clear of bit 19 lands on the capture edge of a new ch3 event
    pin(3, 1'b0, s2, n2);
    @(negedge clk);
    evt[3] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd1; wdata = 32'h0008_0000;
    #1;
    s2 = tod_sec;
    @(negedge clk);
    wr_en = 1'b0;
    exp_rd(10, 4'd1, 32'h000C_0000);
    exp_rd(10, 4'd5, s2);
    wr(4'd1, 32'h0008_0000);
    exp_rd(10, 4'd1, 32'h0004_0000);

    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule